// File: doc/BRIEF.md
# Three-Channel Serial Port Register Front End

This block is the register front end for three serial-port channels behind one bus slave port. The two top address bits pick the channel and the low fourteen bits pick a word register inside it. Each channel keeps line settings, control, queue settings, a transfer-status word, an error word, a queue-status word, transmit and receive data words and a rate divisor. The first two channels also carry a modem control word and a modem status word. The block performs no serial shifting and has no real queues. It keeps the transfer flags, raises the interrupt requests, echoes transmit data into the receive word when asked to, and produces a per-channel rate tick.

Register accesses have side effects. A store to the transmit word marks the transmitter empty and raises the transmit request. A load of the receive word clears the data-ready flag. In loopback mode, and always on the third channel, transmitted data lands in the receive word. Control bits choose whether each request is a held level or a single-cycle pulse.

Top module: `tri_uart_csr`

## Requirements
- R1: The channel is `bus_addr[15:14]` (0, 1 or 2) and the word offset is `bus_addr[13:0]`. Offsets: 0x00 line settings, 0x04 control, 0x08 queue settings, 0x0C modem control, 0x10 transfer status, 0x14 error status, 0x18 queue status, 0x1C modem status, 0x20 transmit data, 0x24 receive data, 0x28 rate divisor. Channels are independent.
- R2: A load from a non-existent offset returns 0xFFFFFFFF, and a store to one changes nothing. This covers channel 3, unaligned offsets, offsets above 0x28, and 0x0C and 0x1C on channel 2.
- R3: After reset the transfer status reads 0x00000006, every other register reads 0, and all request and tick outputs are low.
- R4: A load of the receive word returns its current value and clears status bit 0. If control bit 8 is set, it also drops the receive request.
- R5: A store to the transmit word sets status bits 1 and 2. With control bit 9 set, the transmit request becomes a held level. With bit 9 clear, the held level is dropped and the request is high for exactly one cycle.
- R6: With control bit 5 set, a transmit store also copies the data into the receive word and sets status bit 0. With bit 5 clear on channels 0 and 1, the receive word is untouched.
- R7: Channel 2 performs the copy of R6 on every transmit store, whatever bit 5 holds.
- R8: On such a copy the receive request becomes a held level when control bit 8 is set and a one-cycle pulse otherwise.
- R9: A control store with bit 9 set raises the transmit request as a held level. A control store with bit 8 set drops a held receive request.
- R10: `baud_tick[c]` is a one-cycle pulse once every 16*(D+1) clock enables, where D is divisor bits [15:0]. The enable is every cycle when control bit 10 is clear and `ext_clk_en` when it is set. Storing the divisor restarts the count.
- R11: `err_irq[c]` is high exactly while the channel's error status word is nonzero.
- R12: Every existing register stores the full 32-bit value written and returns it on a load, apart from the hardware flag updates of R4 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 16 | Channel and word offset |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, combinational in the access cycle |
| ext_clk_en | input | 1 | Enable from the external serial clock domain, already synchronised |
| tx_irq | output | 3 | Transmit request per channel |
| rx_irq | output | 3 | Receive request per channel |
| err_irq | output | 3 | Error request per channel |
| baud_tick | output | 3 | Rate tick per channel |

## Verification
A transmit store on a channel that echoes sets the transmit flags, writes the receive word and sets data-ready, all on the same edge. The request outputs take two different styles in that cycle, one chosen by bit 9 and the other by bit 8. The bench provokes this with loopback and level mode on channel 1 and with the forced echo in pulse mode on channel 2. A divisor store that coincides with a clock enable is also provoked, and the restart must win over the count. A behavioural model tracks the registers, both request styles and an enable counter for every channel, and it is compared with the outputs on every clock.

// File: rtl/tri_uart_pkg.sv
package tri_uart_pkg;
  localparam int REG_W = 32;
  localparam int OFF_W = 14;
  localparam int NREG  = 11;

  typedef enum logic [3:0] {
    RI_LINE  = 4'd0,
    RI_CTRL  = 4'd1,
    RI_QCFG  = 4'd2,
    RI_MCTL  = 4'd3,
    RI_STAT  = 4'd4,
    RI_ERR   = 4'd5,
    RI_QSTAT = 4'd6,
    RI_MSTAT = 4'd7,
    RI_TXD   = 4'd8,
    RI_RXD   = 4'd9,
    RI_BDIV  = 4'd10
  } reg_idx_e;

  // control bit positions
  localparam int CB_LOOP   = 5;
  localparam int CB_RXLVL  = 8;
  localparam int CB_TXLVL  = 9;
  localparam int CB_EXTCLK = 10;

  // transfer status bit positions
  localparam int SB_RXRDY = 0;
  localparam logic [REG_W-1:0] STAT_TX_EMPTY = 32'h0000_0006;
  localparam logic [REG_W-1:0] STAT_RESET    = 32'h0000_0006;

  function automatic logic [3:0] reg_slot(input logic [OFF_W-1:0] off);
    return off[5:2];
  endfunction

  function automatic logic reg_hit(input logic [OFF_W-1:0] off, input logic modem_ok);
    logic [3:0] s;
    s = off[5:2];
    if (off[1:0] != 2'b00)        return 1'b0;
    if (off[OFF_W-1:6] != '0)     return 1'b0;
    if (s > 4'(NREG - 1))         return 1'b0;
    if (!modem_ok && (s == RI_MCTL || s == RI_MSTAT)) return 1'b0;
    return 1'b1;
  endfunction

  // status after a transmit store, with or without echo
  function automatic logic [REG_W-1:0] stat_after_tx(input logic [REG_W-1:0] st, input logic echo);
    logic [REG_W-1:0] r;
    r = st | STAT_TX_EMPTY;
    if (echo) r[SB_RXRDY] = 1'b1;
    return r;
  endfunction

  // number of clock enables between two rate ticks
  function automatic int unsigned tick_period(input int unsigned div, input int unsigned presc);
    return presc * (div + 1);
  endfunction
endpackage

// File: rtl/tuart_baud.sv
module tuart_baud #(
  parameter int DIV_W = 16,
  parameter int PRESC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESC - 1);

  logic [DIV_W-1:0] cnt_q;
  logic [PW-1:0]    pre_q;
  logic             expire;
  logic             pre_wrap;

  assign expire   = ce && (cnt_q == '0);
  assign pre_wrap = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (load) begin
        cnt_q <= load_val;
        pre_q <= '0;
      end else if (expire) begin
        cnt_q <= div;
        pre_q <= pre_wrap ? '0 : pre_q + PW'(1);
        tick  <= pre_wrap;
      end else if (ce) begin
        cnt_q <= cnt_q - DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/tuart_chan.sv
module tuart_chan
  import tri_uart_pkg::*;
#(
  parameter bit HAS_MODEM  = 1'b1,
  parameter bit FORCE_ECHO = 1'b0,
  parameter int DIV_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [OFF_W-1:0] off,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             hit,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             err_irq,
  output logic             ext_sel,
  output logic [DIV_W-1:0] div_q,
  output logic             div_load,
  output logic             tx_wr_ev,
  output logic             rx_rd_ev,
  output logic             echo_ev,
  output logic             rx_ready,
  output logic             rx_lvl_mode
);
  logic [REG_W-1:0] regs_q [NREG];
  logic [3:0]       slot;
  logic             wr_ev;
  logic             rd_ev;
  logic             ctrl_wr;
  logic [REG_W-1:0] ctrl;
  logic             tx_lvl_q, tx_pls_q, rx_lvl_q, rx_pls_q;

  assign slot     = reg_slot(off);
  assign hit      = reg_hit(off, HAS_MODEM);
  assign wr_ev    = sel && wr && hit;
  assign rd_ev    = sel && !wr && hit;
  assign ctrl     = regs_q[RI_CTRL];
  assign tx_wr_ev = wr_ev && (slot == RI_TXD);
  assign rx_rd_ev = rd_ev && (slot == RI_RXD);
  assign ctrl_wr  = wr_ev && (slot == RI_CTRL);
  assign div_load = wr_ev && (slot == RI_BDIV);
  assign echo_ev  = tx_wr_ev && (FORCE_ECHO || ctrl[CB_LOOP]);

  assign rdata = hit ? regs_q[slot] : '1;

  // register file with hardware flag updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      regs_q[RI_STAT] <= STAT_RESET;
    end else begin
      if (wr_ev) regs_q[slot] <= wdata;
      if (tx_wr_ev) begin
        regs_q[RI_STAT] <= stat_after_tx(regs_q[RI_STAT], echo_ev);
        if (echo_ev) regs_q[RI_RXD] <= wdata;
      end
      if (rx_rd_ev) regs_q[RI_STAT][SB_RXRDY] <= 1'b0;
    end
  end

  // request flops: held level plus single-cycle pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_lvl_q <= 1'b0;
      tx_pls_q <= 1'b0;
      rx_lvl_q <= 1'b0;
      rx_pls_q <= 1'b0;
    end else begin
      tx_pls_q <= tx_wr_ev && !ctrl[CB_TXLVL];
      rx_pls_q <= echo_ev && !ctrl[CB_RXLVL];
      if (tx_wr_ev)
        tx_lvl_q <= ctrl[CB_TXLVL];
      else if (ctrl_wr && wdata[CB_TXLVL])
        tx_lvl_q <= 1'b1;
      if (echo_ev && ctrl[CB_RXLVL])
        rx_lvl_q <= 1'b1;
      else if ((rx_rd_ev && ctrl[CB_RXLVL]) || (ctrl_wr && wdata[CB_RXLVL]))
        rx_lvl_q <= 1'b0;
    end
  end

  assign tx_irq      = tx_lvl_q | tx_pls_q;
  assign rx_irq      = rx_lvl_q | rx_pls_q;
  assign err_irq     = |regs_q[RI_ERR];
  assign ext_sel     = ctrl[CB_EXTCLK];
  assign div_q       = regs_q[RI_BDIV][DIV_W-1:0];
  assign rx_ready    = regs_q[RI_STAT][SB_RXRDY];
  assign rx_lvl_mode = ctrl[CB_RXLVL];
endmodule

// File: rtl/tuart_decode.sv
module tuart_decode #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 14
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] sel,
  output logic [OFF_W-1:0]  off
);
  localparam int CH_W = ADDR_W - OFF_W;

  logic [CH_W-1:0] ch_field;

  assign ch_field = addr[ADDR_W-1:OFF_W];
  assign off      = addr[OFF_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign sel[c] = valid && (ch_field == CH_W'(c));
  end
endmodule

// File: rtl/tri_uart_csr.sv
module tri_uart_csr
  import tri_uart_pkg::*;
#(
  parameter int                NUM_CH     = 3,
  parameter int                ADDR_W     = 16,
  parameter int                DIV_W      = 16,
  parameter int                PRESC      = 16,
  parameter logic [NUM_CH-1:0] MODEM_MASK = 3'b011,
  parameter logic [NUM_CH-1:0] ECHO_MASK  = 3'b100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ext_clk_en,
  output logic [NUM_CH-1:0] tx_irq,
  output logic [NUM_CH-1:0] rx_irq,
  output logic [NUM_CH-1:0] err_irq,
  output logic [NUM_CH-1:0] baud_tick
);
  logic [NUM_CH-1:0] sel;
  logic [OFF_W-1:0]  off;
  logic [REG_W-1:0]  ch_rdata [NUM_CH];
  logic [NUM_CH-1:0] ch_hit;
  logic [NUM_CH-1:0] ext_sel;
  logic [NUM_CH-1:0] div_load;
  logic [DIV_W-1:0]  div_q [NUM_CH];
  logic [NUM_CH-1:0] tx_wr_ev, rx_rd_ev, echo_ev, rx_ready, rx_lvl_mode;
  logic              bus_hit;

  tuart_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .valid(bus_valid), .addr(bus_addr), .sel(sel), .off(off)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ce;
    tuart_chan #(
      .HAS_MODEM (MODEM_MASK[c]),
      .FORCE_ECHO(ECHO_MASK[c]),
      .DIV_W     (DIV_W)
    ) u_chan (
      .clk(clk), .rst_n(rst_n), .sel(sel[c]), .wr(bus_write), .off(off),
      .wdata(bus_wdata), .rdata(ch_rdata[c]), .hit(ch_hit[c]),
      .tx_irq(tx_irq[c]), .rx_irq(rx_irq[c]), .err_irq(err_irq[c]),
      .ext_sel(ext_sel[c]), .div_q(div_q[c]), .div_load(div_load[c]),
      .tx_wr_ev(tx_wr_ev[c]), .rx_rd_ev(rx_rd_ev[c]), .echo_ev(echo_ev[c]),
      .rx_ready(rx_ready[c]), .rx_lvl_mode(rx_lvl_mode[c])
    );
    assign ce = ext_sel[c] ? ext_clk_en : 1'b1;
    tuart_baud #(.DIV_W(DIV_W), .PRESC(PRESC)) u_baud (
      .clk(clk), .rst_n(rst_n), .ce(ce), .load(div_load[c]),
      .load_val(bus_wdata[DIV_W-1:0]), .div(div_q[c]), .tick(baud_tick[c])
    );
  end

  always_comb begin
    bus_rdata = '1;
    bus_hit   = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel[c]) begin
        bus_rdata = ch_rdata[c];
        bus_hit   = ch_hit[c];
      end
    end
  end
endmodule

// File: rtl/tri_uart_csr_chk.sv
module tri_uart_csr_chk #(
  parameter int                NUM_CH    = 3,
  parameter logic [NUM_CH-1:0] ECHO_MASK = 3'b100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              bus_hit,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] tx_wr_ev,
  input logic [NUM_CH-1:0] rx_rd_ev,
  input logic [NUM_CH-1:0] echo_ev,
  input logic [NUM_CH-1:0] rx_ready,
  input logic [NUM_CH-1:0] rx_lvl_mode,
  input logic [NUM_CH-1:0] tx_irq,
  input logic [NUM_CH-1:0] rx_irq,
  input logic [NUM_CH-1:0] baud_tick
);
  // R2
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !bus_hit) |-> (bus_rdata == 32'hFFFF_FFFF));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5
    tx_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr_ev[c] |=> tx_irq[c]);
    // R4
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rd_ev[c] |=> !rx_ready[c]);
    // R4
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd_ev[c] && rx_lvl_mode[c]) |=> !rx_irq[c]);
    // R8
    echo_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      echo_ev[c] |=> (rx_irq[c] && rx_ready[c]));
    // R10
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick[c] |=> !baud_tick[c]);
    if (ECHO_MASK[c]) begin : g_force
      // R7
      forced_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_ev[c] |-> echo_ev[c]);
    end
  end
endmodule

bind tri_uart_csr tri_uart_csr_chk #(.NUM_CH(NUM_CH), .ECHO_MASK(ECHO_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_hit(bus_hit), .bus_rdata(bus_rdata), .tx_wr_ev(tx_wr_ev),
  .rx_rd_ev(rx_rd_ev), .echo_ev(echo_ev), .rx_ready(rx_ready),
  .rx_lvl_mode(rx_lvl_mode), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .baud_tick(baud_tick)
);

// File: tb/tri_uart_csr_test.sv
module tri_uart_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_clk_en = 1'b0;
  logic [2:0]  tx_irq, rx_irq, err_irq, baud_tick;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int ext_cnt = 0;

  always #10 clk = ~clk;

  tri_uart_csr uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_en(ext_clk_en), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .err_irq(err_irq), .baud_tick(baud_tick)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_reg [3][11];
  bit m_tl[3], m_tp[3], m_rl[3], m_rp[3], m_tick[3];
  int unsigned m_n[3];

  function automatic logic [31:0] m_read(int ch, int off);
    int idx;
    if (ch > 2) return 32'hFFFF_FFFF;
    if ((off % 4) != 0 || off > 40) return 32'hFFFF_FFFF;
    idx = off / 4;
    if (ch == 2 && (idx == 3 || idx == 7)) return 32'hFFFF_FFFF;
    return m_reg[ch][idx];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        for (int i = 0; i < 11; i++) m_reg[c][i] = 32'h0;
        m_reg[c][4] = 32'h6;
        m_tl[c] = 0; m_tp[c] = 0; m_rl[c] = 0; m_rp[c] = 0; m_tick[c] = 0; m_n[c] = 0;
      end
    end else begin
      int ch, off;
      bit hit;
      ch  = int'(bus_addr[15:14]);
      off = int'(bus_addr[13:0]);
      hit = bus_valid && (m_read(ch, off) !== 32'hFFFF_FFFF || (ch <= 2 && (off % 4) == 0 && off <= 40 && !(ch == 2 && (off == 12 || off == 28))));
      for (int c = 0; c < 3; c++) begin
        bit ce;
        m_tp[c] = 0; m_rp[c] = 0;
        ce = m_reg[c][1][10] ? ext_clk_en : 1'b1;
        if (hit && bus_write && ch == c && off == 40) begin
          m_n[c] = 0; m_tick[c] = 0;
        end else if (ce) begin
          m_n[c]++;
          m_tick[c] = (m_n[c] % (16 * (int'(m_reg[c][10][15:0]) + 1))) == 0;
        end else m_tick[c] = 0;
      end
      if (hit && bus_write) begin
        logic [31:0] ctl;
        ctl = m_reg[ch][1];
        m_reg[ch][off/4] = bus_wdata;
        if (off == 4) begin
          if (bus_wdata[9]) m_tl[ch] = 1;
          if (bus_wdata[8]) m_rl[ch] = 0;
        end
        if (off == 32) begin
          m_reg[ch][4] |= 32'h6;
          if (ctl[9]) m_tl[ch] = 1; else begin m_tl[ch] = 0; m_tp[ch] = 1; end
          if (ctl[5] || ch == 2) begin
            m_reg[ch][9] = bus_wdata;
            m_reg[ch][4] |= 32'h1;
            if (ctl[8]) m_rl[ch] = 1; else m_rp[ch] = 1;
          end
        end
      end else if (hit && !bus_write && off == 36) begin
        m_reg[ch][4] &= ~32'h1;
        if (m_reg[ch][1][8]) m_rl[ch] = 0;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    ext_cnt++;
    ext_clk_en = (ext_cnt % 3) == 0;
    if (rst_n && !done) begin
      for (int c = 0; c < 3; c++) begin
        check("R5/R9 tx_irq vs model", 32'(tx_irq[c]), 32'(m_tl[c] | m_tp[c]));
        check("R4/R8 rx_irq vs model", 32'(rx_irq[c]), 32'(m_rl[c] | m_rp[c]));
        check("R11 err_irq vs model", 32'(err_irq[c]), 32'(|m_reg[c][5]));
        check("R10 baud_tick vs model", 32'(baud_tick[c]), 32'(m_tick[c]));
      end
    end
  end

  task automatic bus_wr(int ch, int off, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = {2'(ch), 14'(off)}; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(int ch, int off, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = {2'(ch), 14'(off)};
    #1;
    d = bus_rdata;
    check("R12 load vs model", bus_rdata, m_read(ch, off));
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic tick_gap(int c, output int p);
    int k = 0;
    while (!baud_tick[c] && k < 5000) begin @(negedge clk); k++; end
    p = 0;
    do begin @(negedge clk); p++; end while (!baud_tick[c] && p < 5000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int p;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R3 reset state
    bus_rd(0, 16, d); check("R3 status reset", d, 32'h6);
    bus_rd(0, 4, d);  check("R3 control reset", d, 32'h0);
    bus_rd(1, 40, d); check("R3 divisor reset", d, 32'h0);
    check("R3 requests low", 32'({tx_irq, rx_irq, err_irq}), 32'h0);
    // R2 unmapped offsets
    bus_rd(3, 0, d);  check("R2 channel 3", d, 32'hFFFF_FFFF);
    bus_rd(2, 12, d); check("R2 ch2 modem ctrl", d, 32'hFFFF_FFFF);
    bus_rd(2, 28, d); check("R2 ch2 modem status", d, 32'hFFFF_FFFF);
    bus_rd(0, 44, d); check("R2 above 0x28", d, 32'hFFFF_FFFF);
    bus_rd(0, 6, d);  check("R2 unaligned", d, 32'hFFFF_FFFF);
    bus_wr(2, 12, 32'h55);
    bus_rd(2, 12, d); check("R2 ignored store", d, 32'hFFFF_FFFF);
    bus_wr(3, 0, 32'h77);
    bus_rd(0, 0, d);  check("R2 no alias ch3", d, 32'h0);
    // R1 / R12 decode and storage
    bus_wr(1, 0, 32'h0000_0003);
    bus_rd(1, 0, d);  check("R1 ch1 line", d, 32'h3);
    bus_rd(0, 0, d);  check("R1 ch0 isolated", d, 32'h0);
    bus_wr(0, 28, 32'hCAFE_00AB);
    bus_rd(0, 28, d); check("R12 ch0 modem status", d, 32'hCAFE_00AB);
    // R5 transmit store, pulse style
    bus_wr(0, 16, 32'h0);
    bus_wr(0, 32, 32'h11);
    check("R5 tx pulse high", 32'(tx_irq[0]), 32'h1);
    @(negedge clk);
    check("R5 tx pulse gone", 32'(tx_irq[0]), 32'h0);
    bus_rd(0, 16, d); check("R5 status bits", d, 32'h6);
    bus_rd(0, 36, d); check("R6 no echo without loop", d, 32'h0);
    // R9 control store raises transmit level
    bus_wr(0, 4, 32'h200);
    check("R9 tx level", 32'(tx_irq[0]), 32'h1);
    repeat (3) @(negedge clk);
    check("R9 tx level held", 32'(tx_irq[0]), 32'h1);
    bus_wr(0, 32, 32'h22);
    repeat (2) @(negedge clk);
    check("R5 tx level after store", 32'(tx_irq[0]), 32'h1);
    // R6 / R8 / R4 loopback with level receive
    bus_wr(1, 4, 32'h120);
    bus_wr(1, 32, 32'hA5);
    check("R8 rx level", 32'(rx_irq[1]), 32'h1);
    bus_rd(1, 16, d); check("R6 ready set", d, 32'h7);
    check("R8 rx level held", 32'(rx_irq[1]), 32'h1);
    bus_rd(1, 36, d); check("R6 echoed data", d, 32'hA5);
    check("R4 rx dropped", 32'(rx_irq[1]), 32'h0);
    bus_rd(1, 16, d); check("R4 ready cleared", d, 32'h6);
    // R7 / R8 forced echo on channel 2, pulse style
    bus_wr(2, 32, 32'h3C);
    check("R8 rx pulse high", 32'(rx_irq[2]), 32'h1);
    @(negedge clk);
    check("R8 rx pulse gone", 32'(rx_irq[2]), 32'h0);
    bus_rd(2, 36, d); check("R7 forced echo data", d, 32'h3C);
    // R9 control store drops receive level
    bus_wr(1, 32, 32'h5A);
    check("R9 rx level before", 32'(rx_irq[1]), 32'h1);
    bus_wr(1, 4, 32'h100);
    check("R9 rx level dropped", 32'(rx_irq[1]), 32'h0);
    // R11 error request
    bus_wr(1, 20, 32'h4);
    check("R11 err high", 32'(err_irq), 32'h2);
    bus_wr(1, 20, 32'h0);
    check("R11 err low", 32'(err_irq), 32'h0);
    // R10 rate ticks
    bus_wr(0, 40, 32'h2);
    tick_gap(0, p); check("R10 ch0 div 2", 32'(p), 32'd48);
    bus_wr(2, 40, 32'h0001_0001);
    tick_gap(2, p); check("R10 low 16 bits only", 32'(p), 32'd32);
    bus_rd(2, 40, d); check("R12 divisor stored", d, 32'h0001_0001);
    bus_wr(1, 4, 32'h400);
    tick_gap(1, p); tick_gap(1, p);
    check("R10 external enable", 32'(p), 32'd48);
    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule